// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave port that lets a host read and write three 32-bit configuration words inside a converter: a signed offset trim, an unsigned gain trim and a control word. The host selects the word with a 3-bit code in a command byte. Every frame is an 8-bit command followed by 32 data bits, and both are sent most significant bit first. The three words also leave the block on parallel outputs, so the converter logic can use them directly. The 4-bit data-rate field and the filter-select bit of the control word also have outputs of their own.

The single serial output line has two jobs. While read data is being shifted out, it carries that data. At all other times it shows the inverse of the converter's new-data flag, so a host can watch the line fall to learn that a sample is waiting. The line is enabled only while chip select is low. A separate enable output stands for its high-impedance state.

A status flag shows that the port has come out of reset. The flag is set by reset and is cleared once the host completes a read of the control word. Writing a control word with its reset bit set starts a reset cycle. That cycle puts every register back to its default value and raises a one-cycle reset pulse. The serial pins are synchronised into the system clock domain and sampled there.

Top module: `cfg_spi_slave`

## Requirements
- R1: After reset the parallel outputs read offset 0x00000000, gain 0x01000000 and control 0x10000000. The stored control word is 0x00000000, and bit 28 of the control output is the reset flag, which reset sets to 1.
- R2: A frame is 8 command bits followed by 32 data bits, MSB first, with the input sampled on rising SCLK. In the command byte, bit 7 set to 1 means read and 0 means write, and bits 2:0 are the register select. Bits 6:3 are ignored.
- R3: The select codes are 3'b001 for offset, 3'b010 for gain and 3'b011 for control. A write updates the selected register once the 40th rising edge has been seen.
- R4: In a read frame, the output presents data bit 31 after the falling edge that follows the command byte. Each later falling edge presents the next lower bit.
- R5: Select codes other than 001, 010 and 011 read as all zeros. Writes to those codes change no register.
- R6: Control bit 28 is read-only: it returns the reset flag, and written values of this bit are discarded. A completed read of the control word clears the flag.
- R7: Writing the control word with bit 29 set to 1 gives a single-cycle reset pulse and restores all three registers to their defaults. It also sets the reset flag. Bit 29 is never stored, so it always reads 0.
- R8: While chip select is low and no read data is shifting, the serial output equals the inverse of the new-data input.
- R9: The output enable is low whenever chip select is high. Raising chip select in the middle of a frame aborts it, so no register is written and the next frame starts cleanly.
- R10: With chip select held low, frames follow one another back to back, and each is decoded on its own.
- R11: The rate output is control bits 19:16, and the filter-select output is control bit 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_csn | input | 1 | Active-low chip select |
| spi_sdi | input | 1 | Serial data from host |
| conv_ready_i | input | 1 | Converter has a new sample |
| spi_sdo | output | 1 | Serial data / inverted data-ready |
| spi_sdo_oe | output | 1 | Output enable; low means high impedance |
| ofs_o | output | 32 | Offset trim word |
| gain_o | output | 32 | Gain trim word |
| conf_o | output | 32 | Control word, bit 28 is the reset flag |
| rate_sel_o | output | 4 | Data-rate field |
| filt_sel_o | output | 1 | Filter-select bit |
| sys_rst_o | output | 1 | One-cycle reset pulse from a control write |

## Verification
The output-enable property assumes that chip select is held high while reset is active. It also assumes that the pin is seen through exactly two synchroniser stages, so the enable lags the pin by two clock cycles. The register properties assume that SCLK phases last long enough for each edge to be seen once after synchronisation. The stimulus holds every SCLK phase and chip-select setup for six system clocks, and it keeps chip select high throughout reset.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
    localparam int CMD_W    = 8;
    localparam int DATA_W   = 32;
    localparam int SEL_W    = 3;
    localparam int SYNC_DEPTH = 2;

    localparam logic [SEL_W-1:0] SEL_OFS  = 3'b001;
    localparam logic [SEL_W-1:0] SEL_GAIN = 3'b010;
    localparam logic [SEL_W-1:0] SEL_CONF = 3'b011;

    localparam logic [DATA_W-1:0] OFS_RST  = 32'h0000_0000;
    localparam logic [DATA_W-1:0] GAIN_RST = 32'h0100_0000;
    localparam logic [DATA_W-1:0] CONF_RST = 32'h0000_0000;

    localparam int RV_BIT    = 28;
    localparam int RST_BIT   = 29;
    localparam int RATE_LSB  = 16;
    localparam int RATE_W    = 4;
    localparam int FILT_BIT  = 20;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= {stg_q[STAGES-2:0], d};
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
    parameter int CMD_W  = 8,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_act,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [SEL_W-1:0]  rd_sel,
    output logic              wr_stb,
    output logic              rd_done,
    output logic [SEL_W-1:0]  ev_sel,
    output logic [DATA_W-1:0] wr_data,
    output logic              shifting,
    output logic              sdo_bit
);
    localparam int FRAME = CMD_W + DATA_W;
    localparam int CNT_W = $clog2(FRAME + 1);
    localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME - 1);

    typedef struct packed {
        logic              sclk_prev;
        logic [CNT_W-1:0]  cnt;
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] din;
        logic [DATA_W-1:0] dout;
        logic              arm;
        logic              shifting;
        logic              wr_stb;
        logic              rd_done;
        logic [SEL_W-1:0]  ev_sel;
    } fe_t;

    fe_t fe_d, fe_q;
    logic rise, fall;

    always_comb begin
        fe_d           = fe_q;
        fe_d.wr_stb    = 1'b0;
        fe_d.rd_done   = 1'b0;
        fe_d.sclk_prev = sclk_s;
        rise = sclk_s & ~fe_q.sclk_prev;
        fall = ~sclk_s & fe_q.sclk_prev;
        if (!cs_act) begin
            fe_d.cnt      = '0;
            fe_d.arm      = 1'b0;
            fe_d.shifting = 1'b0;
        end else begin
            if (rise) begin
                if (fe_q.cnt <= CMD_LAST) fe_d.cmd = {fe_q.cmd[CMD_W-2:0], sdi_s};
                else                      fe_d.din = {fe_q.din[DATA_W-2:0], sdi_s};
                // command complete: its MSB (read flag) is the bit now at CMD_W-2
                if (fe_q.cnt == CMD_LAST) fe_d.arm = fe_q.cmd[CMD_W-2];
                if (fe_q.cnt == FRAME_LAST) begin
                    fe_d.cnt     = '0;
                    fe_d.ev_sel  = fe_q.cmd[SEL_W-1:0];
                    fe_d.wr_stb  = ~fe_q.cmd[CMD_W-1];
                    fe_d.rd_done = fe_q.cmd[CMD_W-1];
                end else begin
                    fe_d.cnt = fe_q.cnt + 1'b1;
                end
            end
            if (fall) begin
                if (fe_q.arm) begin
                    fe_d.dout     = rd_data;
                    fe_d.shifting = 1'b1;
                    fe_d.arm      = 1'b0;
                end else if (fe_q.shifting) begin
                    if (fe_q.cnt == '0) fe_d.shifting = 1'b0;
                    else                fe_d.dout = {fe_q.dout[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fe_q <= '0;
        else        fe_q <= fe_d;
    end

    assign rd_sel   = fe_q.cmd[SEL_W-1:0];
    assign wr_stb   = fe_q.wr_stb;
    assign rd_done  = fe_q.rd_done;
    assign ev_sel   = fe_q.ev_sel;
    assign wr_data  = fe_q.din;
    assign shifting = fe_q.shifting;
    assign sdo_bit  = fe_q.dout[DATA_W-1];
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
    import spi_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic              wr_stb,
    input  logic              rd_done,
    input  logic [SEL_W-1:0]  ev_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] ofs_o,
    output logic [DATA_W-1:0] gain_o,
    output logic [DATA_W-1:0] conf_o,
    output logic              sys_rst_o
);
    typedef struct packed {
        logic [DATA_W-1:0] ofs;
        logic [DATA_W-1:0] gain;
        logic [DATA_W-1:0] conf;
        logic              rv;
        logic              rst_pls;
    } rf_t;

    localparam rf_t RF_RST = '{ofs: OFS_RST, gain: GAIN_RST, conf: CONF_RST,
                               rv: 1'b1, rst_pls: 1'b0};

    rf_t rf_d, rf_q;
    logic [DATA_W-1:0] conf_view;

    always_comb begin
        rf_d         = rf_q;
        rf_d.rst_pls = 1'b0;
        if (wr_stb) begin
            case (ev_sel)
                SEL_OFS:  rf_d.ofs  = wr_data;
                SEL_GAIN: rf_d.gain = wr_data;
                SEL_CONF: begin
                    if (wr_data[RST_BIT]) begin
                        rf_d         = RF_RST;
                        rf_d.rst_pls = 1'b1;
                    end else begin
                        rf_d.conf          = wr_data;
                        rf_d.conf[RV_BIT]  = 1'b0;
                        rf_d.conf[RST_BIT] = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        if (rd_done && ev_sel == SEL_CONF) rf_d.rv = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= RF_RST;
        else        rf_q <= rf_d;
    end

    always_comb begin
        conf_view         = rf_q.conf;
        conf_view[RV_BIT] = rf_q.rv;
        case (rd_sel)
            SEL_OFS:  rd_data = rf_q.ofs;
            SEL_GAIN: rd_data = rf_q.gain;
            SEL_CONF: rd_data = conf_view;
            default:  rd_data = '0;
        endcase
    end

    assign ofs_o     = rf_q.ofs;
    assign gain_o    = rf_q.gain;
    assign conf_o    = conf_view;
    assign sys_rst_o = rf_q.rst_pls;
endmodule

// File: rtl/cfg_spi_slave.sv
module cfg_spi_slave
    import spi_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_csn,
    input  logic              spi_sdi,
    input  logic              conv_ready_i,
    output logic              spi_sdo,
    output logic              spi_sdo_oe,
    output logic [DATA_W-1:0] ofs_o,
    output logic [DATA_W-1:0] gain_o,
    output logic [DATA_W-1:0] conf_o,
    output logic [RATE_W-1:0] rate_sel_o,
    output logic              filt_sel_o,
    output logic              sys_rst_o
);
    logic [2:0]        pins_s;
    logic              sclk_s, csn_s, sdi_s;
    logic [SEL_W-1:0]  rd_sel, ev_sel;
    logic              wr_stb, rd_done, shifting, sdo_bit;
    logic [DATA_W-1:0] wr_data, rd_data;

    spi_pin_sync #(.W(3), .STAGES(SYNC_DEPTH), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_sclk, spi_csn, spi_sdi}), .q(pins_s)
    );
    assign {sclk_s, csn_s, sdi_s} = pins_s;

    spi_frame_engine #(.CMD_W(CMD_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_fe (
        .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_act(~csn_s), .sdi_s(sdi_s),
        .rd_data(rd_data), .rd_sel(rd_sel), .wr_stb(wr_stb), .rd_done(rd_done),
        .ev_sel(ev_sel), .wr_data(wr_data), .shifting(shifting), .sdo_bit(sdo_bit)
    );

    spi_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .wr_stb(wr_stb), .rd_done(rd_done),
        .ev_sel(ev_sel), .wr_data(wr_data), .rd_data(rd_data),
        .ofs_o(ofs_o), .gain_o(gain_o), .conf_o(conf_o), .sys_rst_o(sys_rst_o)
    );

    assign spi_sdo    = shifting ? sdo_bit : ~conv_ready_i;
    assign spi_sdo_oe = ~csn_s;
    assign rate_sel_o = conf_o[RATE_LSB +: RATE_W];
    assign filt_sel_o = conf_o[FILT_BIT];
endmodule

// File: rtl/cfg_spi_slave_chk.sv
module cfg_spi_slave_chk
    import spi_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              spi_csn,
    input logic              spi_sdo_oe,
    input logic              wr_stb,
    input logic              rd_done,
    input logic [SEL_W-1:0]  ev_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] ofs_o,
    input logic [DATA_W-1:0] gain_o,
    input logic [DATA_W-1:0] conf_o,
    input logic              sys_rst_o
);
    // enable follows the pin through the SYNC_DEPTH (=2) synchroniser stages
    AST_OE_TRACKS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sdo_oe == !$past(spi_csn, 2)); // R9

    AST_OFS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && ev_sel == SEL_OFS) |=> ofs_o == $past(wr_data)); // R3

    AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && ev_sel != SEL_OFS && ev_sel != SEL_GAIN && ev_sel != SEL_CONF)
        |=> ($stable(ofs_o) && $stable(gain_o) && $stable(conf_o))); // R5

    AST_SYSRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> (ofs_o == OFS_RST && gain_o == GAIN_RST && conf_o[RV_BIT])); // R7

    AST_SYSRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |=> !sys_rst_o); // R7

    AST_RV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && ev_sel == SEL_CONF) |=> !conf_o[RV_BIT]); // R6
endmodule

bind cfg_spi_slave cfg_spi_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sdo_oe(spi_sdo_oe),
    .wr_stb(wr_stb), .rd_done(rd_done), .ev_sel(ev_sel), .wr_data(wr_data),
    .ofs_o(ofs_o), .gain_o(gain_o), .conf_o(conf_o), .sys_rst_o(sys_rst_o)
);

// File: tb/cfg_spi_slave_bench.sv
module cfg_spi_slave_bench;
    localparam int H = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, csn = 1'b1, sdi = 1'b0, rdy = 1'b0;
    logic        sdo, sdo_oe, filt, srst;
    logic [31:0] ofs, gain, conf;
    logic [3:0]  rate;
    int          n_tests = 0, n_fail = 0, rst_pulses = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    cfg_spi_slave u_cfg_spi_slave (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_sdi(sdi),
        .conv_ready_i(rdy), .spi_sdo(sdo), .spi_sdo_oe(sdo_oe),
        .ofs_o(ofs), .gain_o(gain), .conf_o(conf), .rate_sel_o(rate),
        .filt_sel_o(filt), .sys_rst_o(srst)
    );

    always @(posedge clk) if (srst) rst_pulses++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] cmd, input logic [31:0] wd,
                         input bit keep_cs, output logic [31:0] rd);
        rd = '0;
        csn = 1'b0;
        wait_n(H);
        for (int i = 0; i < 40; i++) begin
            sdi = (i < 8) ? cmd[7-i] : wd[39-i];
            wait_n(H);
            if (i >= 8) rd[39-i] = sdo;
            sclk = 1'b1;
            wait_n(H);
            sclk = 1'b0;
        end
        wait_n(H);
        if (!keep_cs) csn = 1'b1;
        wait_n(H);
    endtask

    task automatic t_reset();
        chk("R1 ofs", ofs, 32'h0);
        chk("R1 gain", gain, 32'h0100_0000);
        chk("R1 conf", conf, 32'h1000_0000);
        chk("R9 oe idle", {31'b0, sdo_oe}, 32'h0);
    endtask

    task automatic t_idle_dout();
        csn = 1'b0; rdy = 1'b1; wait_n(H);
        chk("R9 oe active", {31'b0, sdo_oe}, 32'h1);
        chk("R8 ready", {31'b0, sdo}, 32'h0);
        rdy = 1'b0; wait_n(2);
        chk("R8 not ready", {31'b0, sdo}, 32'h1);
        csn = 1'b1; wait_n(H);
    endtask

    task automatic t_rw();
        logic [31:0] r;
        frame(8'h01, 32'hA5C3_0F96, 1'b0, r);
        chk("R3 ofs write", ofs, 32'hA5C3_0F96);
        rdy = 1'b1;
        frame(8'h81, 32'h0, 1'b0, r);
        chk("R4 ofs read", r, 32'hA5C3_0F96);
        rdy = 1'b0;
        frame(8'h02, 32'h00FF_1234, 1'b0, r);
        chk("R3 gain write", gain, 32'h00FF_1234);
        frame(8'h82, 32'hFFFF_FFFF, 1'b0, r);
        chk("R4 gain read", r, 32'h00FF_1234);
        frame(8'h7A, 32'h1357_9BDF, 1'b0, r);
        chk("R2 ignored cmd bits", gain, 32'h1357_9BDF);
    endtask

    task automatic t_reserved();
        logic [31:0] r;
        frame(8'h04, 32'hFFFF_FFFF, 1'b0, r);
        chk("R5 ofs kept", ofs, 32'hA5C3_0F96);
        chk("R5 gain kept", gain, 32'h1357_9BDF);
        chk("R5 conf kept", conf, 32'h1000_0000);
        frame(8'h80, 32'h0, 1'b0, r);
        chk("R5 read sel0", r, 32'h0);
        frame(8'h87, 32'h0, 1'b0, r);
        chk("R5 read sel7", r, 32'h0);
    endtask

    task automatic t_conf();
        logic [31:0] r;
        frame(8'h83, 32'h0, 1'b0, r);
        chk("R6 rv first read", r, 32'h1000_0000);
        frame(8'h83, 32'h0, 1'b0, r);
        chk("R6 rv cleared", r, 32'h0);
        frame(8'h03, 32'h101B_0000, 1'b0, r);
        frame(8'h83, 32'h0, 1'b0, r);
        chk("R6 bit28 write dropped", r, 32'h001B_0000);
        chk("R11 rate", {28'b0, rate}, 32'hB);
        chk("R11 filter", {31'b0, filt}, 32'h1);
    endtask

    task automatic t_sysrst();
        logic [31:0] r;
        frame(8'h03, 32'h2000_0005, 1'b0, r);
        chk("R7 pulse count", rst_pulses, 32'd1);
        chk("R7 ofs default", ofs, 32'h0);
        chk("R7 gain default", gain, 32'h0100_0000);
        chk("R7 conf default", conf, 32'h1000_0000);
        frame(8'h83, 32'h0, 1'b0, r);
        chk("R7 read after reset", r, 32'h1000_0000);
    endtask

    task automatic t_abort();
        logic [31:0] r;
        frame(8'h01, 32'h0BAD_CAFE, 1'b0, r);
        csn = 1'b0; wait_n(H);
        for (int i = 0; i < 20; i++) begin
            sdi = (i < 8) ? 8'h01 >> (7 - i) : 1'b1;
            wait_n(H); sclk = 1'b1; wait_n(H); sclk = 1'b0;
        end
        wait_n(H); csn = 1'b1; wait_n(H);
        chk("R9 abort oe", {31'b0, sdo_oe}, 32'h0);
        chk("R9 abort no write", ofs, 32'h0BAD_CAFE);
        frame(8'h81, 32'h0, 1'b0, r);
        chk("R9 next frame clean", r, 32'h0BAD_CAFE);
    endtask

    task automatic t_tied();
        logic [31:0] r;
        frame(8'h01, 32'h1111_2222, 1'b1, r);
        frame(8'h02, 32'h3333_4444, 1'b1, r);
        frame(8'h81, 32'h0, 1'b1, r);
        chk("R10 ofs", ofs, 32'h1111_2222);
        chk("R10 gain", gain, 32'h3333_4444);
        chk("R10 read back", r, 32'h1111_2222);
        rdy = 1'b1; wait_n(2);
        chk("R8 after read", {31'b0, sdo}, 32'h0);
        rdy = 1'b0; csn = 1'b1; wait_n(H);
    endtask

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(5);
        t_reset();
        t_idle_dout();
        t_rw();
        t_reserved();
        t_conf();
        t_sysrst();
        t_abort();
        t_tied();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule